// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit CPU

This block works out the operand address of one instruction for an 8-bit accumulator CPU with a 16-bit address bus. The decoder gives it an addressing-mode code, the address of the first operand byte, and the current X and Y index values. The block then fetches the operand bytes, and the pointer bytes where the mode needs them, one byte per request over a simple request/valid memory port. It returns the final address, the program counter after the operand, and a flag that asks the sequencer for one extra cycle.

Zero-page arithmetic stays inside page zero. This holds for indexed zero-page modes and for both bytes of a pointer fetch. Absolute-indexed reads and indirect-indexed reads charge one extra cycle when indexing moves the address into another 256-byte page. Stores never pay that cycle. For relative branches the block gives both the destination and the follow-on PC, and it flags a taken branch that lands in a different page.

Top module: `ea_unit`

## Requirements
- R1: `mode_i` codes are 0 zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 pre-indexed indirect (zero page+X, then pointer), 7 post-indexed indirect (pointer, then +Y), 8 relative. For zero page the address is `{0x00, operand}`, `new_pc_o` is `pc_i+1` and the penalty is 0.
- R2: Zero page+X and zero page+Y add the index to the operand byte modulo 256, so the high address byte is always 0x00.
- R3: Absolute modes read the low byte at `pc_i` and the high byte at `pc_i+1`, and return `new_pc_o = pc_i+2`.
- R4: Absolute+X and absolute+Y return base+index over the full 16 bits. For a read, `penalty_o` is 1 exactly when bit 8 of the base differs from bit 8 of the result.
- R5: When `store_i` is high, the indexed modes return the same address with `penalty_o` 0.
- R6: Pre-indexed indirect reads a little-endian pointer with its low byte at (operand+X) mod 256 and its high byte at (operand+X+1) mod 256. The pointer is the address and the penalty is 0.
- R7: Post-indexed indirect reads the pointer at operand and (operand+1) mod 256, then returns pointer+Y. For a read, the penalty follows the bit-8 rule of R4.
- R8: Relative mode sign-extends the operand and adds it to `pc_i+1` to give `ea_o`. When taken, `new_pc_o` is that target and `penalty_o` is 1 when its high byte differs from that of `pc_i+1`. When not taken, `new_pc_o` is `pc_i+1` and `penalty_o` is 0.
- R9: At most one read is outstanding. `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i`. The block advances only on `mem_valid_i`, so results do not depend on memory latency. Reads per instruction are 1 for zero-page and relative modes, 2 for absolute modes and 3 for indirect modes.
- R10: After reset `done_o` and `mem_req_o` are 0. `done_o` is a single-cycle pulse, and `ea_o`, `new_pc_o` and `penalty_o` are valid in that cycle. `penalty_o` is 0 whenever `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address calculation (sampled when idle) |
| mode_i | input | 4 | Addressing-mode code |
| store_i | input | 1 | Instruction writes memory (suppresses page penalty) |
| take_i | input | 1 | Branch condition is true (relative mode) |
| pc_i | input | 16 | Address of the first operand byte |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |
| done_o | output | 1 | Result valid, one cycle |
| ea_o | output | 16 | Effective address or branch target |
| new_pc_o | output | 16 | Program counter after the operand |
| penalty_o | output | 1 | One extra cycle is due |

## Verification
A wrong sequencer state shows at the memory port first. A missing or surplus fetch, or a pointer read outside page zero, appears on `mem_addr_o` within a cycle of the faulty transition, and the fetch counts per mode expose it. Wrong operand or pointer registers show on `ea_o` in the same `done_o` cycle. A wrong carry or sign treatment shows only in the page-crossing and backward-branch cases, so those are driven on purpose. These cases include the wrap from 0xFFFF to 0x0000 and the pointer read that wraps at 0xFF. Running the same checks with a slow memory shows whether a state advances without waiting for valid.

// File: rtl/ea_unit_pkg.sv
package ea_unit_pkg;
  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7,
    AM_REL  = 4'd8
  } am_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OPLO, S_OPHI, S_PLO, S_PHI, S_FIN
  } st_e;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] idx_i,
  output logic [AW-1:0] sum_o,
  output logic          crossed_o
);
  localparam int HW = AW - DW;
  assign sum_o     = base_i + {{HW{1'b0}}, idx_i};
  assign crossed_o = sum_o[DW] ^ base_i[DW];
endmodule

// File: rtl/ea_branch_calc.sv
module ea_branch_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] next_pc_i,
  input  logic [DW-1:0] off_i,
  input  logic          taken_i,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] new_pc_o,
  output logic          penalty_o
);
  localparam int HW = AW - DW;
  assign target_o  = next_pc_i + {{HW{off_i[DW-1]}}, off_i};
  assign new_pc_o  = taken_i ? target_o : next_pc_i;
  assign penalty_o = taken_i && (target_o[AW-1:DW] != next_pc_i[AW-1:DW]);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_unit_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic          store_i,
  input  logic          take_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] new_pc_o,
  output logic          penalty_o
);
  localparam int HW = AW - DW;

  st_e           state_q;
  am_e           mode_q;
  logic          store_q, take_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] x_q, y_q, op_lo_q, op_hi_q, ptr_lo_q;

  logic          is_abs, is_ind;
  logic [DW-1:0] idx, zp_ptr, zp_ptr_hi, zp_sum;
  logic [AW-1:0] idx_base, idx_sum, br_target, br_new_pc;
  logic          idx_cross, br_pen;

  assign is_abs    = (mode_q == AM_ABS) || (mode_q == AM_ABSX) || (mode_q == AM_ABSY);
  assign is_ind    = (mode_q == AM_INDX) || (mode_q == AM_INDY);
  assign idx       = ((mode_q == AM_ZPX) || (mode_q == AM_ABSX)) ? x_q : y_q;
  assign zp_ptr    = (mode_q == AM_INDX) ? op_lo_q + x_q : op_lo_q;
  assign zp_ptr_hi = zp_ptr + 1'b1;
  assign zp_sum    = op_lo_q + idx;
  assign idx_base  = (mode_q == AM_INDY) ? {op_hi_q, ptr_lo_q} : {op_hi_q, op_lo_q};

  ea_index_add #(.AW(AW), .DW(DW)) u_idx (
    .base_i(idx_base), .idx_i(idx), .sum_o(idx_sum), .crossed_o(idx_cross)
  );

  ea_branch_calc #(.AW(AW), .DW(DW)) u_br (
    .next_pc_i(pc_q), .off_i(op_lo_q), .taken_i(take_q),
    .target_o(br_target), .new_pc_o(br_new_pc), .penalty_o(br_pen)
  );

  // sequencer: one byte per request, advance only on valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= AM_ZP;
      store_q  <= 1'b0;
      take_q   <= 1'b0;
      pc_q     <= '0;
      x_q      <= '0;
      y_q      <= '0;
      op_lo_q  <= '0;
      op_hi_q  <= '0;
      ptr_lo_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_OPLO;
          mode_q  <= am_e'(mode_i);
          store_q <= store_i;
          take_q  <= take_i;
          pc_q    <= pc_i;
          x_q     <= x_i;
          y_q     <= y_i;
          op_hi_q <= '0;
        end
        S_OPLO: if (mem_valid_i) begin
          op_lo_q <= mem_rdata_i;
          pc_q    <= pc_q + 1'b1;
          state_q <= is_abs ? S_OPHI : (is_ind ? S_PLO : S_FIN);
        end
        S_OPHI: if (mem_valid_i) begin
          op_hi_q <= mem_rdata_i;
          pc_q    <= pc_q + 1'b1;
          state_q <= S_FIN;
        end
        S_PLO: if (mem_valid_i) begin
          ptr_lo_q <= mem_rdata_i;
          state_q  <= S_PHI;
        end
        S_PHI: if (mem_valid_i) begin
          op_hi_q <= mem_rdata_i;
          state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b1;
    mem_addr_o = pc_q;
    unique case (state_q)
      S_PLO:   mem_addr_o = {{HW{1'b0}}, zp_ptr};
      S_PHI:   mem_addr_o = {{HW{1'b0}}, zp_ptr_hi};
      S_OPLO, S_OPHI: mem_addr_o = pc_q;
      default: mem_req_o  = 1'b0;
    endcase
  end

  always_comb begin
    ea_o = {{HW{1'b0}}, op_lo_q};
    unique case (mode_q)
      AM_ZPX, AM_ZPY:           ea_o = {{HW{1'b0}}, zp_sum};
      AM_ABS:                   ea_o = {op_hi_q, op_lo_q};
      AM_ABSX, AM_ABSY, AM_INDY: ea_o = idx_sum;
      AM_INDX:                  ea_o = {op_hi_q, ptr_lo_q};
      AM_REL:                   ea_o = br_target;
      default:                  ea_o = {{HW{1'b0}}, op_lo_q};
    endcase
  end

  assign done_o    = (state_q == S_FIN);
  assign new_pc_o  = (mode_q == AM_REL) ? br_new_pc : pc_q;
  assign penalty_o = done_o &&
                     (((mode_q == AM_REL) && br_pen) ||
                      (((mode_q == AM_ABSX) || (mode_q == AM_ABSY) || (mode_q == AM_INDY))
                       && idx_cross && !store_q));
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_unit_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          penalty_o,
  input logic [AW-1:0] ea_o,
  input logic          mem_req_o,
  input logic          mem_valid_i,
  input logic [AW-1:0] mem_addr_o,
  input am_e           mode_q,
  input logic          store_q
);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_pen_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penalty_o |-> done_o);

  assert_zp_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (ea_o[AW-1:DW] == '0));

  assert_store_no_pen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && store_q && mode_q != AM_REL) |-> !penalty_o);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_no_req_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

bind ea_unit ea_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .penalty_o(penalty_o),
  .ea_o(ea_o), .mem_req_o(mem_req_o), .mem_valid_i(mem_valid_i),
  .mem_addr_o(mem_addr_o), .mode_q(mode_q), .store_q(store_q)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        store = 1'b0, take = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  x = '0, y = '0;
  logic        mem_req, mem_valid;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        done, penalty;
  logic [15:0] ea, new_pc;

  int checks = 0, fails = 0, nfetch = 0, lat = 0, wait_cnt = 0;
  logic [7:0] mem [int];

  always #2 clk = ~clk;

  ea_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .store_i(store),
    .take_i(take), .pc_i(pc), .x_i(x), .y_i(y), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .done_o(done), .ea_o(ea), .new_pc_o(new_pc), .penalty_o(penalty)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hEE;
  endfunction

  // behavioural memory with programmable wait cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0; mem_rdata <= '0; wait_cnt <= 0;
    end else begin
      mem_valid <= 1'b0;
      if (mem_req && !mem_valid) begin
        if (wait_cnt >= lat) begin
          mem_valid <= 1'b1; mem_rdata <= rd(mem_addr);
          wait_cnt <= 0; nfetch <= nfetch + 1;
        end else wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] m, input logic st, input logic tk,
                     input logic [15:0] p, input logic [7:0] xi, input logic [7:0] yi,
                     input logic [15:0] e_ea, input logic [15:0] e_pc, input logic e_pen,
                     input int e_fetch);
    int f0, n;
    @(negedge clk);
    mode = m; store = st; take = tk; pc = p; x = xi; y = yi; start = 1'b1;
    f0 = nfetch;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL %s R10 actual=no done expected=done", tag);
    end else begin
      chk({tag, " ea"}, {16'h0, ea}, {16'h0, e_ea});
      chk({tag, " new_pc"}, {16'h0, new_pc}, {16'h0, e_pc});
      chk({tag, " penalty"}, {31'h0, penalty}, {31'h0, e_pen});
      chk({tag, " R9 fetches"}, nfetch - f0, e_fetch);
      @(negedge clk);
      chk({tag, " R10 done pulse"}, {31'h0, done}, 32'h0);
      chk({tag, " R10 penalty idle"}, {31'h0, penalty}, 32'h0);
    end
  endtask

  task automatic t_reset;
    chk("R10 reset done", {31'h0, done}, 32'h0);
    chk("R10 reset req", {31'h0, mem_req}, 32'h0);
  endtask

  task automatic t_zero_page;
    run("R1 zp", 4'd0, 0, 0, 16'h0200, 8'h11, 8'h22, 16'h0042, 16'h0201, 0, 1);
    run("R2 zpx wrap", 4'd1, 0, 0, 16'h0210, 8'h20, 8'h00, 16'h0010, 16'h0211, 0, 1);
    run("R2 zpy ff", 4'd2, 0, 0, 16'h0220, 8'h00, 8'h7F, 16'h00FF, 16'h0221, 0, 1);
    run("R2 zpy wrap", 4'd2, 0, 0, 16'h0220, 8'h00, 8'h80, 16'h0000, 16'h0221, 0, 1);
  endtask

  task automatic t_absolute;
    run("R3 abs", 4'd3, 0, 0, 16'h0230, 8'hFF, 8'hFF, 16'h1234, 16'h0232, 0, 2);
    run("R4 absx same page", 4'd4, 0, 0, 16'h0240, 8'h05, 8'h00, 16'h3015, 16'h0242, 0, 2);
    run("R4 absx cross", 4'd4, 0, 0, 16'h0250, 8'h20, 8'h00, 16'h3110, 16'h0252, 1, 2);
    run("R5 absy store cross", 4'd5, 1, 0, 16'h0250, 8'h00, 8'h20, 16'h3110, 16'h0252, 0, 2);
    run("R4 absy wrap ffff", 4'd5, 0, 0, 16'h0270, 8'h00, 8'h01, 16'h0000, 16'h0272, 1, 2);
  endtask

  task automatic t_indirect;
    run("R6 pre-indexed", 4'd6, 0, 0, 16'h0280, 8'h04, 8'h00, 16'h5678, 16'h0281, 0, 3);
    run("R6 pre-indexed wrap", 4'd6, 0, 0, 16'h0290, 8'h01, 8'h00, 16'hABCD, 16'h0291, 0, 3);
    run("R7 post-indexed cross", 4'd7, 0, 0, 16'h02A0, 8'h00, 8'h20, 16'h1310, 16'h02A1, 1, 3);
    run("R5 post-indexed store", 4'd7, 1, 0, 16'h02A0, 8'h00, 8'h20, 16'h1310, 16'h02A1, 0, 3);
    run("R7 post-indexed same", 4'd7, 0, 0, 16'h02A0, 8'h00, 8'h05, 16'h12F5, 16'h02A1, 0, 3);
    run("R7 post-indexed wrap", 4'd7, 0, 0, 16'h02B0, 8'h00, 8'h00, 16'hABCD, 16'h02B1, 0, 3);
  endtask

  task automatic t_branch;
    run("R8 taken fwd", 4'd8, 0, 1, 16'h02C0, 8'h00, 8'h00, 16'h02D1, 16'h02D1, 0, 1);
    run("R8 not taken", 4'd8, 0, 0, 16'h02C0, 8'h00, 8'h00, 16'h02D1, 16'h02C1, 0, 1);
    run("R8 taken back cross", 4'd8, 0, 1, 16'h0300, 8'h00, 8'h00, 16'h0281, 16'h0281, 1, 1);
    run("R8 not taken back", 4'd8, 1, 0, 16'h0300, 8'h00, 8'h00, 16'h0281, 16'h0301, 0, 1);
    run("R8 taken fwd cross", 4'd8, 0, 1, 16'h02F0, 8'h00, 8'h00, 16'h0370, 16'h0370, 1, 1);
  endtask

  task automatic t_slow_memory;
    lat = 3;
    run("R9 slow abs", 4'd4, 0, 0, 16'h0250, 8'h20, 8'h00, 16'h3110, 16'h0252, 1, 2);
    run("R9 slow indirect", 4'd6, 0, 0, 16'h0290, 8'h01, 8'h00, 16'hABCD, 16'h0291, 0, 3);
    lat = 0;
  endtask

  initial begin
    mem[32'h0200] = 8'h42; mem[32'h0210] = 8'hF0; mem[32'h0220] = 8'h80;
    mem[32'h0230] = 8'h34; mem[32'h0231] = 8'h12;
    mem[32'h0240] = 8'h10; mem[32'h0241] = 8'h30;
    mem[32'h0250] = 8'hF0; mem[32'h0251] = 8'h30;
    mem[32'h0270] = 8'hFF; mem[32'h0271] = 8'hFF;
    mem[32'h0280] = 8'h20; mem[32'h0024] = 8'h78; mem[32'h0025] = 8'h56;
    mem[32'h0290] = 8'hFE; mem[32'h00FF] = 8'hCD; mem[32'h0000] = 8'hAB;
    mem[32'h02A0] = 8'h40; mem[32'h0040] = 8'hF0; mem[32'h0041] = 8'h12;
    mem[32'h02B0] = 8'hFF;
    mem[32'h02C0] = 8'h10; mem[32'h0300] = 8'h80; mem[32'h02F0] = 8'h7F;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_page();
    t_absolute();
    t_indirect();
    t_branch();
    t_slow_memory();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule